// File: doc/BRIEF.md
# Per-Queue Chunk Batcher for a Hybrid On-Chip/DRAM Packet Buffer

This block sits in front of a banked DRAM packet store and collects fixed-size cells for many queues. Each arriving cell, one 512-bit beat on a valid/ready interface, is tagged with a queue number. It is parked in that queue's small on-chip tail stage. Once a queue holds a whole chunk of cells, the chunk goes to DRAM in one request. The bank for that request comes from a round-robin pointer that belongs to the queue alone, so each queue spreads its chunks evenly over all banks.

On the output side, each queue has an on-chip head stage of two chunks. A consumer picks a queue and pops its oldest cell. Head stages are refilled from DRAM one chunk at a time. Every queue keeps a small FIFO of the banks it wrote to, so chunks come back in the order they were stored. When several head stages want a refill, the one closest to running dry is served first.

The DRAM side is one set of per-bank request and acknowledge lines with a shared queue tag and shared data buses. The block keeps at most one DRAM operation open at a time.

Top module: `queue_tail_batcher`

## Requirements
- R1: After reset, `in_ready` is high for every queue, `q_empty` is all ones, `out_valid` is low and no DRAM request line is raised.
- R2: No DRAM write is raised for a queue until it has taken 4 cells. The write then carries those 4 cells in arrival order, the first cell in bits [511:0] and each later cell in the next 512 bits, with `dr_queue` equal to the queue number.
- R3: The chunks of a queue go to banks 0, 1, 2, 3, 0, ... in turn, counted for that queue alone from reset. Bank b is selected by raising bit b of `dr_wr_req`.
- R4: While a queue holds 4 staged cells whose write has not yet been acknowledged, `in_ready` is low for that queue. It rises again after the acknowledge.
- R5: When several queues have a full chunk waiting while the DRAM side is idle, the lowest queue number is written first. A waiting write is issued before any refill read.
- R6: At most one bit across `dr_wr_req` and `dr_rd_req` is high. A raised request keeps its lines and `dr_queue` unchanged until the matching bank's `dr_ack` bit is seen.
- R7: Chunks are read from the bank each one was written to, in write order, so that each queue yields its cells in exactly the order they were accepted.
- R8: A refill read is eligible for a queue that has a chunk in DRAM and at most 4 cells in its head stage. Among eligible queues, the one with the fewest head cells is served first, and on a tie the lower queue number wins.
- R9: `out_valid` is high when the head stage of `out_queue` holds a cell. `out_cell` is then the oldest such cell, and `out_pop` with `out_valid` removes it.
- R10: Bit q of `q_empty` is high exactly when queue q has no staged tail cells, no chunks in DRAM and no head cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Cell offered |
| in_queue | input | 3 | Queue of the offered cell |
| in_cell | input | 512 | Cell data |
| in_ready | output | 1 | Queue `in_queue` can take a cell |
| out_queue | input | 3 | Queue selected for output |
| out_pop | input | 1 | Remove the presented cell |
| out_valid | output | 1 | Head stage of `out_queue` is non-empty |
| out_cell | output | 512 | Oldest head cell of `out_queue` |
| q_empty | output | 8 | Per-queue empty flags |
| dr_wr_req | output | 4 | Per-bank chunk write request |
| dr_rd_req | output | 4 | Per-bank chunk read request |
| dr_queue | output | 3 | Queue owning the open request |
| dr_wdata | output | 2048 | Chunk being written |
| dr_ack | input | 4 | Per-bank completion |
| dr_rdata | input | 2048 | Chunk returned with a read acknowledge |

## Verification
A short directed burst into one queue separates the staging threshold from early writes and shows the input stall while the write is open. A stalled DRAM with two queues filling behind it shows whether the lowest queue wins the write. Three busy queues whose heads are drained to different depths, with the DRAM held, expose whether refill follows head depth or queue number. Long random traffic with random pops, replayed against a per-queue scoreboard and a bank model that keeps one FIFO per bank and queue, shows any bank misrouting or reordering as wrong output data.

// File: rtl/queue_tail_batcher.sv
module queue_tail_batcher #(
  parameter int NQ = 8,
  parameter int NB = 4,
  parameter int CHUNK = 4,
  parameter int CELL_BITS = 512,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [$clog2(NQ)-1:0]       in_queue,
  input  logic [CELL_BITS-1:0]        in_cell,
  output logic                        in_ready,
  input  logic [$clog2(NQ)-1:0]       out_queue,
  input  logic                        out_pop,
  output logic                        out_valid,
  output logic [CELL_BITS-1:0]        out_cell,
  output logic [NQ-1:0]               q_empty,
  output logic [NB-1:0]               dr_wr_req,
  output logic [NB-1:0]               dr_rd_req,
  output logic [$clog2(NQ)-1:0]       dr_queue,
  output logic [CHUNK*CELL_BITS-1:0]  dr_wdata,
  input  logic [NB-1:0]               dr_ack,
  input  logic [CHUNK*CELL_BITS-1:0]  dr_rdata
);
  localparam int QW  = $clog2(NQ);
  localparam int BW  = $clog2(NB);
  localparam int CHW = $clog2(CHUNK);
  localparam int TCW = $clog2(CHUNK + 1);
  localparam int HW  = $clog2(2 * CHUNK);
  localparam int HCW = $clog2(2 * CHUNK + 1);
  localparam int DW  = $clog2(DEPTH);
  localparam int DCW = $clog2(DEPTH + 1);

  logic [CELL_BITS-1:0] tail_mem [NQ][CHUNK];
  logic [CELL_BITS-1:0] head_mem [NQ][2*CHUNK];
  logic [BW-1:0]        bank_log [NQ][DEPTH];
  logic [TCW-1:0] tcnt [NQ];
  logic [HCW-1:0] hcnt [NQ];
  logic [HW-1:0]  hrd  [NQ];
  logic [DCW-1:0] dcnt [NQ];
  logic [DW-1:0]  lrd  [NQ];
  logic [BW-1:0]  rr   [NQ];

  logic          busy, op_rd;
  logic [QW-1:0] op_q;
  logic [BW-1:0] op_b;
  logic          wr_hit, rd_hit;
  logic [QW-1:0] wr_q, rd_q;
  logic          done, accept, pop;
  logic [NQ-1:0] acc_v, pop_v, wdone_v, rdone_v;

  assign in_ready  = tcnt[in_queue] != TCW'(CHUNK);
  assign accept    = in_valid && in_ready;
  assign out_valid = hcnt[out_queue] != '0;
  assign out_cell  = head_mem[out_queue][hrd[out_queue]];
  assign pop       = out_pop && out_valid;
  assign done      = busy && dr_ack[op_b];

  assign acc_v   = accept ? (NQ'(1) << in_queue) : '0;
  assign pop_v   = pop ? (NQ'(1) << out_queue) : '0;
  assign wdone_v = (done && !op_rd) ? (NQ'(1) << op_q) : '0;
  assign rdone_v = (done && op_rd) ? (NQ'(1) << op_q) : '0;

  assign dr_wr_req = (busy && !op_rd) ? (NB'(1) << op_b) : '0;
  assign dr_rd_req = (busy && op_rd) ? (NB'(1) << op_b) : '0;
  assign dr_queue  = op_q;

  for (genvar c = 0; c < CHUNK; c++) begin : g_wdata
    assign dr_wdata[c*CELL_BITS +: CELL_BITS] = tail_mem[op_q][c];
  end

  for (genvar g = 0; g < NQ; g++) begin : g_empty
    assign q_empty[g] = (tcnt[g] == '0) && (dcnt[g] == '0) && (hcnt[g] == '0);
  end

  always_comb begin
    wr_hit = 1'b0;
    wr_q   = '0;
    for (int q = NQ - 1; q >= 0; q--)
      if (tcnt[q] == TCW'(CHUNK) && dcnt[q] < DCW'(DEPTH)) begin
        wr_hit = 1'b1;
        wr_q   = QW'(q);
      end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_q   = '0;
    for (int q = 0; q < NQ; q++)
      if (dcnt[q] != '0 && hcnt[q] <= HCW'(CHUNK) && (!rd_hit || hcnt[q] < hcnt[rd_q])) begin
        rd_hit = 1'b1;
        rd_q   = QW'(q);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      op_rd <= 1'b0;
      op_q  <= '0;
      op_b  <= '0;
      for (int q = 0; q < NQ; q++) begin
        tcnt[q] <= '0;
        hcnt[q] <= '0;
        hrd[q]  <= '0;
        dcnt[q] <= '0;
        lrd[q]  <= '0;
        rr[q]   <= '0;
      end
    end else begin
      if (!busy) begin
        if (wr_hit) begin
          busy  <= 1'b1;
          op_rd <= 1'b0;
          op_q  <= wr_q;
          op_b  <= rr[wr_q];
        end else if (rd_hit) begin
          busy  <= 1'b1;
          op_rd <= 1'b1;
          op_q  <= rd_q;
          op_b  <= bank_log[rd_q][lrd[rd_q]];
        end
      end else if (done) begin
        busy <= 1'b0;
      end
      for (int q = 0; q < NQ; q++) begin
        if (acc_v[q])        tcnt[q] <= tcnt[q] + 1'b1;
        else if (wdone_v[q]) tcnt[q] <= '0;
        if (wdone_v[q]) rr[q]  <= rr[q] + 1'b1;
        if (rdone_v[q]) lrd[q] <= lrd[q] + 1'b1;
        if (pop_v[q])   hrd[q] <= hrd[q] + 1'b1;
        dcnt[q] <= dcnt[q] + DCW'(wdone_v[q]) - DCW'(rdone_v[q]);
        hcnt[q] <= hcnt[q] - HCW'(pop_v[q]) + ({HCW{rdone_v[q]}} & HCW'(CHUNK));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept)
      tail_mem[in_queue][tcnt[in_queue][CHW-1:0]] <= in_cell;
    if (done && !op_rd)
      bank_log[op_q][DW'(lrd[op_q] + dcnt[op_q])] <= op_b;
    if (done && op_rd)
      for (int c = 0; c < CHUNK; c++)
        head_mem[op_q][HW'(hrd[op_q] + hcnt[op_q] + HCW'(c))] <= dr_rdata[c*CELL_BITS +: CELL_BITS];
  end
endmodule

// File: rtl/queue_tail_batcher_chk.sv
module queue_tail_batcher_chk #(
  parameter int NQ = 8,
  parameter int NB = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [$clog2(NQ)-1:0] in_queue,
  input logic                  in_ready,
  input logic [$clog2(NQ)-1:0] out_queue,
  input logic                  out_valid,
  input logic [NQ-1:0]         q_empty,
  input logic [NB-1:0]         dr_wr_req,
  input logic [NB-1:0]         dr_rd_req,
  input logic [$clog2(NQ)-1:0] dr_queue,
  input logic [NB-1:0]         dr_ack
);
  // R6
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dr_wr_req, dr_rd_req}));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(dr_wr_req | dr_rd_req)) && !(|((dr_wr_req | dr_rd_req) & dr_ack)))
      |=> ($stable(dr_wr_req) && $stable(dr_rd_req) && $stable(dr_queue)));

  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dr_wr_req) && in_queue == dr_queue) |-> !in_ready);

  // R10
  empty_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty[out_queue] |-> !out_valid);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dr_wr_req == '0 && dr_rd_req == '0));
endmodule

bind queue_tail_batcher queue_tail_batcher_chk #(.NQ(NQ), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_queue(in_queue), .in_ready(in_ready),
  .out_queue(out_queue), .out_valid(out_valid), .q_empty(q_empty),
  .dr_wr_req(dr_wr_req), .dr_rd_req(dr_rd_req), .dr_queue(dr_queue), .dr_ack(dr_ack)
);

// File: tb/test_queue_tail_batcher.sv
`timescale 1ns/1ps
module test_queue_tail_batcher;
  localparam int NQ = 8, NB = 4, CHUNK = 4, CB = 512, DEPTH = 8, LAT = 3;
  localparam int KW = CHUNK * CB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_pop = 1'b0;
  logic [2:0] in_queue = '0, out_queue = '0;
  logic [CB-1:0] in_cell = '0;
  logic in_ready, out_valid;
  logic [CB-1:0] out_cell;
  logic [NQ-1:0] q_empty;
  logic [NB-1:0] dr_wr_req, dr_rd_req;
  logic [NB-1:0] dr_ack = '0;
  logic [2:0] dr_queue;
  logic [KW-1:0] dr_wdata;
  logic [KW-1:0] dr_rdata = '0;

  queue_tail_batcher i_queue_tail_batcher (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_queue(in_queue), .in_cell(in_cell),
    .in_ready(in_ready), .out_queue(out_queue), .out_pop(out_pop), .out_valid(out_valid),
    .out_cell(out_cell), .q_empty(q_empty), .dr_wr_req(dr_wr_req), .dr_rd_req(dr_rd_req),
    .dr_queue(dr_queue), .dr_wdata(dr_wdata), .dr_ack(dr_ack), .dr_rdata(dr_rdata)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [CB-1:0] exp_c [NQ][256];
  int ewp [NQ], erp [NQ], wchunk [NQ], nbank [NQ];
  logic [KW-1:0] bmem [NB][NQ][8];
  int bwp [NB][NQ], brd [NB][NQ];
  int wlog [64], rlog [64];
  int wn = 0, rn = 0, lat_cnt = 0;
  bit hold = 1'b0;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected at most 150000", cycles);
      finish_sim();
    end
  end

  function automatic logic [CB-1:0] rnd_cell();
    logic [CB-1:0] v;
    for (int i = 0; i < CB / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic serve();
    int b = 0;
    int q = int'(dr_queue);
    logic [KW-1:0] ech;
    for (int i = 0; i < NB; i++) if (dr_wr_req[i] || dr_rd_req[i]) b = i;
    chk($countones({dr_wr_req, dr_rd_req}) == 1,
        $sformatf("R6 request lines: actual %0d raised, expected 1", $countones({dr_wr_req, dr_rd_req})));
    if (|dr_wr_req) begin
      chk(b == nbank[q], $sformatf("R3 queue %0d bank: actual %0d expected %0d", q, b, nbank[q]));
      nbank[q] = (nbank[q] + 1) % NB;
      for (int i = 0; i < CHUNK; i++) ech[i*CB +: CB] = exp_c[q][(wchunk[q] * CHUNK + i) % 256];
      chk(dr_wdata == ech, $sformatf("R2 queue %0d chunk data: actual %h expected %h", q, dr_wdata, ech));
      wchunk[q]++;
      bmem[b][q][bwp[b][q] % 8] = dr_wdata;
      bwp[b][q]++;
      wlog[wn % 64] = q;
      wn++;
    end else begin
      dr_rdata = bmem[b][q][brd[b][q] % 8];
      brd[b][q]++;
      rlog[rn % 64] = q;
      rn++;
    end
    dr_ack[b] = 1'b1;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      dr_ack = '0;
      lat_cnt = 0;
    end else if (|dr_ack) begin
      dr_ack = '0;
      lat_cnt = 0;
    end else if ((|{dr_wr_req, dr_rd_req}) && !hold) begin
      lat_cnt++;
      if (lat_cnt >= LAT) serve();
    end
  end

  task automatic cyc(input bit s, input int sq, input bit p, input int pq, output bit sent, output bit popped);
    @(negedge clk);
    in_queue = 3'(sq);
    out_queue = 3'(pq);
    in_cell = rnd_cell();
    #1;
    sent = s && in_ready;
    in_valid = sent;
    if (sent) begin
      exp_c[sq][ewp[sq] % 256] = in_cell;
      ewp[sq]++;
    end
    popped = p && out_valid;
    out_pop = popped;
    if (popped) begin
      chk(out_cell == exp_c[pq][erp[pq] % 256],
          $sformatf("R7 queue %0d cell %0d: actual %h expected %h", pq, erp[pq], out_cell, exp_c[pq][erp[pq] % 256]));
      erp[pq]++;
    end
  endtask

  task automatic idle(input int n, input int q);
    bit s, p;
    for (int i = 0; i < n; i++) cyc(0, q, 0, q, s, p);
  endtask

  task automatic send_n(input int q, input int n);
    bit s, p;
    int k = 0;
    while (k < n) begin
      cyc(1, q, 0, 0, s, p);
      if (s) k++;
    end
  endtask

  task automatic pop_n(input int q, input int n);
    bit s, p;
    int k = 0;
    while (k < n) begin
      cyc(0, 0, 1, q, s, p);
      if (p) k++;
    end
  endtask

  task automatic drain_all();
    bit s, p;
    int quiet = 0;
    while (quiet < 60) begin
      bit any = 0;
      for (int q = 0; q < NQ; q++) begin
        cyc(0, 0, 1, q, s, p);
        if (p) any = 1;
      end
      if (any) quiet = 0; else quiet++;
    end
    idle(1, 0);
  endtask

  task automatic check_empty(input string tag);
    for (int q = 0; q < NQ; q++) begin
      bit e = (ewp[q] == erp[q]);
      chk(q_empty[q] == e, $sformatf("R10 %s queue %0d empty: actual %0b expected %0b", tag, q, q_empty[q], e));
    end
  endtask

  initial begin
    bit s, p;
    int w0, r0;
    void'($urandom(32'd2024));
    for (int q = 0; q < NQ; q++) begin
      ewp[q] = 0; erp[q] = 0; wchunk[q] = 0; nbank[q] = 0;
      for (int b = 0; b < NB; b++) begin bwp[b][q] = 0; brd[b][q] = 0; end
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(in_ready == 1'b1, $sformatf("R1 in_ready: actual %0b expected 1", in_ready));
    chk(q_empty == '1, $sformatf("R1 q_empty: actual %b expected all ones", q_empty));
    chk(out_valid == 1'b0, $sformatf("R1 out_valid: actual %0b expected 0", out_valid));
    chk({dr_wr_req, dr_rd_req} == '0, $sformatf("R1 requests: actual %b expected 0", {dr_wr_req, dr_rd_req}));

    // R2: three cells must not trigger a write
    send_n(2, 3);
    idle(8, 2);
    chk(dr_wr_req == '0, $sformatf("R2 write after 3 cells: actual %b expected 0000", dr_wr_req));
    chk(q_empty[2] == 1'b0, $sformatf("R10 partial tail q2 empty: actual %0b expected 0", q_empty[2]));
    send_n(2, 1);
    idle(2, 2);
    chk(dr_wr_req == 4'b0001 && dr_queue == 3'd2,
        $sformatf("R2/R3 write: actual req %b queue %0d expected 0001 queue 2", dr_wr_req, dr_queue));
    // R4
    chk(in_ready == 1'b0, $sformatf("R4 in_ready while write open: actual %0b expected 0", in_ready));
    idle(12, 2);
    chk(in_ready == 1'b1, $sformatf("R4 in_ready after ack: actual %0b expected 1", in_ready));
    chk(out_valid == 1'b1, $sformatf("R9 out_valid after refill: actual %0b expected 1", out_valid));
    pop_n(2, 4);
    idle(1, 2);
    chk(out_valid == 1'b0, $sformatf("R9 out_valid after pops: actual %0b expected 0", out_valid));
    send_n(2, 1);

    // R5: lowest queue wins among waiting writes
    hold = 1'b1;
    send_n(7, 4);
    idle(3, 7);
    send_n(6, 4);
    send_n(1, 4);
    w0 = wn;
    hold = 1'b0;
    idle(40, 0);
    chk(wlog[w0 % 64] == 7, $sformatf("R5 first write: actual q%0d expected q7", wlog[w0 % 64]));
    chk(wlog[(w0 + 1) % 64] == 1, $sformatf("R5 second write: actual q%0d expected q1", wlog[(w0 + 1) % 64]));
    chk(wlog[(w0 + 2) % 64] == 6, $sformatf("R5 third write: actual q%0d expected q6", wlog[(w0 + 2) % 64]));
    drain_all();

    // R8: refill goes to the shallowest head
    send_n(0, 12);
    send_n(3, 12);
    send_n(4, 12);
    idle(100, 0);
    hold = 1'b1;
    send_n(0, 4);
    pop_n(3, 6);
    pop_n(4, 7);
    r0 = rn;
    hold = 1'b0;
    idle(40, 0);
    chk(rlog[r0 % 64] == 4, $sformatf("R8 first refill: actual q%0d expected q4", rlog[r0 % 64]));
    chk(rlog[(r0 + 1) % 64] == 3, $sformatf("R8 second refill: actual q%0d expected q3", rlog[(r0 + 1) % 64]));
    drain_all();
    check_empty("directed");

    // Random traffic, R7 and R3 checked on every pop and write
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 2) == 1, int'($urandom % NQ), ($urandom % 4) != 0, int'($urandom % NQ), s, p);
    drain_all();
    check_empty("random");
    finish_sim();
  end
endmodule